// File: doc/BRIEF.md
# LED Shift-Chain Controller

This block drives an external daisy-chain of serial-in, parallel-out shift registers, up to 24 stages long, so that a few pins light a row of LEDs. Software places a word in a data register. On each update the block sends the active part of that word out on a serial data pin, starting with the most significant bit, under a shift clock that it generates. It then raises a store strobe, which makes the chain present the word on its parallel outputs.

An update starts in one of two ways. Software can set a request bit. The block can also refresh on its own at one of four rates, derived from the system clock through a prescaler. The chain length follows from which 8-bit groups are enabled. The active shift-clock edge can be chosen. Two hardware status inputs can take the place of the two lowest bits of the word.

Register access uses a single request channel. Every request is taken in the cycle it is offered. Data for a read comes back one cycle later, marked with a valid pulse that cannot be stalled. The block never applies back-pressure, and a requester need not wait between requests.

Top module: `led_chain_ctrl`

## Requirements
- R1: After reset, all five registers read as zero, and the serial data, shift clock and store outputs are all low.
- R2: The registers sit at byte offsets 0x00 (control A), 0x04 (control B), 0x08 (chain data, bits 23:0 kept, upper bits read 0), 0x0C (spare data) and 0x10 (spare access), all 32 bits. A read returns its data with `rd_valid` in the cycle after it is accepted. Unmapped offsets read 0. `host_ready` is always high. Control A bit 31 always reads 0.
- R3: An update sends the chosen number of bits highest first. After the store strobe, chain stage n holds bit n of the word.
- R4: Control B bits 2:0 enable 8-bit groups covering bits 7:0, 15:8 and 23:16. The length is 8 times the highest enabled group index plus 8. With no group enabled, any update request is discarded and no shift occurs.
- R5: With control A bit 26 at 0, the data is valid on the rising shift-clock edge and the clock rests low. With bit 26 at 1, the data is valid on the falling edge and the clock rests high. Each bit lasts 2*HALF_CYC cycles.
- R6: After the last bit, the store output is high for exactly 2*HALF_CYC cycles, with the serial data low and the shift clock steady.
- R7: When control A bits 25:24 are both 1, bits 1:0 of the sent word come from `hw_stat[1:0]`. Any other value of those two bits leaves the word unchanged.
- R8: Writing 1 to control A bit 31 requests one update. A request made while a shift is running is held and served once, right after that shift ends, using the chain data current at that time.
- R9: When control B bits 31:30 equal 2'b10, an update starts every UNIT_CYCLES times 20, 10, 5 or 4 cycles, for rate field bits 26:23 equal to 0, 1, 2 or 3. Rate codes above 3 behave like code 0. Any other source value gives no periodic update.
- R10: A periodic tick that comes while a shift is running is dropped, not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Register request offered |
| host_ready | output | 1 | Request accepted (always high) |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset of the register |
| host_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| hw_stat | input | 2 | Hardware status that can replace word bits 1:0 |
| chain_sdo | output | 1 | Serial data to the chain |
| chain_sclk | output | 1 | Shift clock to the chain |
| chain_store | output | 1 | Store strobe to the chain |

## Verification
The bench builds the block with UNIT_CYCLES = 16 and HALF_CYC = 2. With these values a full 24-bit update takes 100 cycles and the refresh periods are 320, 160, 80 and 64 cycles. Every group mask, both clock edges and all four override codes can then be swept, with varied data, in a short run. The two fastest rates become shorter than a full-length shift, so a dropped tick shows up as a doubled interval between store pulses.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;
  localparam int OFF_CTRL_A = 'h00;
  localparam int OFF_CTRL_B = 'h04;
  localparam int OFF_DATA   = 'h08;
  localparam int OFF_SPARE  = 'h0C;
  localparam int OFF_ACCESS = 'h10;

  localparam int BIT_SW_REQ  = 31;
  localparam int BIT_FALL    = 26;
  localparam int BIT_OVR_HI  = 25;
  localparam int BIT_OVR_LO  = 24;
  localparam int BIT_SRC_HI  = 31;
  localparam int BIT_SRC_LO  = 30;
  localparam int BIT_RATE_HI = 26;
  localparam int BIT_RATE_LO = 23;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_SHIFT = 2'd1,
    SH_LATCH = 2'd2
  } sh_state_t;
endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
  import led_chain_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int CHAIN_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic [31:0]       ctrl_a,
  output logic [31:0]       ctrl_b,
  output logic [CHAIN_W-1:0] data_word,
  output logic              sw_req
);
  logic [31:0] spare_q, access_q;
  logic        wr_en, rd_en;

  assign wr_en = host_valid && host_write;
  assign rd_en = host_valid && !host_write;

  assign sw_req = wr_en && (host_addr == ADDR_W'(OFF_CTRL_A)) && host_wdata[BIT_SW_REQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a    <= '0;
      ctrl_b    <= '0;
      data_word <= '0;
      spare_q   <= '0;
      access_q  <= '0;
    end else if (wr_en) begin
      if (host_addr == ADDR_W'(OFF_CTRL_A)) begin
        ctrl_a <= host_wdata & ~(32'd1 << BIT_SW_REQ);
      end
      if (host_addr == ADDR_W'(OFF_CTRL_B)) begin
        ctrl_b <= host_wdata;
      end
      if (host_addr == ADDR_W'(OFF_DATA)) begin
        data_word <= host_wdata[CHAIN_W-1:0];
      end
      if (host_addr == ADDR_W'(OFF_SPARE)) begin
        spare_q <= host_wdata;
      end
      if (host_addr == ADDR_W'(OFF_ACCESS)) begin
        access_q <= host_wdata;
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (host_addr == ADDR_W'(OFF_CTRL_A)) rd_mux = ctrl_a;
    if (host_addr == ADDR_W'(OFF_CTRL_B)) rd_mux = ctrl_b;
    if (host_addr == ADDR_W'(OFF_DATA))   rd_mux = 32'(data_word);
    if (host_addr == ADDR_W'(OFF_SPARE))  rd_mux = spare_q;
    if (host_addr == ADDR_W'(OFF_ACCESS)) rd_mux = access_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= rd_mux;
      end
    end
  end
endmodule

// File: rtl/lsc_rate.sv
module lsc_rate #(
  parameter int UNIT_CYCLES = 1250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_en,
  input  logic [3:0] rate_code,
  output logic       tick
);
  localparam int CNT_W = $clog2(UNIT_CYCLES * 20 + 1);
  localparam logic [CNT_W-1:0] LIM_R0 = CNT_W'(UNIT_CYCLES * 20 - 1);
  localparam logic [CNT_W-1:0] LIM_R1 = CNT_W'(UNIT_CYCLES * 10 - 1);
  localparam logic [CNT_W-1:0] LIM_R2 = CNT_W'(UNIT_CYCLES * 5 - 1);
  localparam logic [CNT_W-1:0] LIM_R3 = CNT_W'(UNIT_CYCLES * 4 - 1);

  logic [CNT_W-1:0] cnt, limit;

  always_comb begin
    case (rate_code)
      4'd1:    limit = LIM_R1;
      4'd2:    limit = LIM_R2;
      4'd3:    limit = LIM_R3;
      default: limit = LIM_R0;
    endcase
  end

  assign tick = auto_en && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!auto_en || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lsc_shift.sv
module lsc_shift
  import led_chain_pkg::*;
#(
  parameter int GROUP_W    = 8,
  parameter int MAX_GROUPS = 3,
  parameter int HALF_CYC   = 50,
  localparam int CHAIN_W   = GROUP_W * MAX_GROUPS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  sw_req,
  input  logic [MAX_GROUPS-1:0] grp_en,
  input  logic                  fall_live,
  input  logic                  ovr_en,
  input  logic [1:0]            hw_stat,
  input  logic [CHAIN_W-1:0]    word,
  output logic                  sdo,
  output logic                  sclk,
  output logic                  store,
  output logic                  busy
);
  localparam int IDX_W = $clog2(CHAIN_W);
  localparam int HC_W  = $clog2(2 * HALF_CYC + 1);
  localparam logic [HC_W-1:0] HALF_LAST  = HC_W'(HALF_CYC - 1);
  localparam logic [HC_W-1:0] LATCH_LAST = HC_W'(2 * HALF_CYC - 1);

  sh_state_t          state;
  logic               phase, fall_q, pend;
  logic [HC_W-1:0]    hcnt;
  logic [IDX_W-1:0]   bit_idx, len_m1;
  logic [CHAIN_W-1:0] snap, word_eff;
  logic               any_grp, idle, start, drop_pend;

  always_comb begin
    len_m1 = '0;
    for (int g = 0; g < MAX_GROUPS; g++) begin
      if (grp_en[g]) len_m1 = IDX_W'((g + 1) * GROUP_W - 1);
    end
  end

  always_comb begin
    word_eff = word;
    if (ovr_en) word_eff[1:0] = hw_stat;
  end

  assign any_grp   = |grp_en;
  assign idle      = (state == SH_IDLE);
  assign start     = idle && any_grp && (pend || tick);
  assign drop_pend = start || (idle && !any_grp);
  assign busy      = !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else begin
      pend <= sw_req || (pend && !drop_pend);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SH_IDLE;
      phase   <= 1'b0;
      fall_q  <= 1'b0;
      hcnt    <= '0;
      bit_idx <= '0;
      snap    <= '0;
    end else begin
      case (state)
        SH_IDLE: begin
          if (start) begin
            snap    <= word_eff;
            bit_idx <= len_m1;
            fall_q  <= fall_live;
            phase   <= 1'b0;
            hcnt    <= '0;
            state   <= SH_SHIFT;
          end
        end
        SH_SHIFT: begin
          if (hcnt == HALF_LAST) begin
            hcnt <= '0;
            if (!phase) begin
              phase <= 1'b1;
            end else if (bit_idx == '0) begin
              phase <= 1'b0;
              state <= SH_LATCH;
            end else begin
              phase   <= 1'b0;
              bit_idx <= bit_idx - 1'b1;
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        SH_LATCH: begin
          if (hcnt == LATCH_LAST) begin
            hcnt  <= '0;
            state <= SH_IDLE;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

  assign sdo   = (state == SH_SHIFT) ? snap[bit_idx] : 1'b0;
  assign store = (state == SH_LATCH);
  always_comb begin
    case (state)
      SH_SHIFT: sclk = phase ^ fall_q;
      SH_LATCH: sclk = fall_q;
      default:  sclk = fall_live;
    endcase
  end
endmodule

// File: rtl/led_chain_ctrl.sv
module led_chain_ctrl
  import led_chain_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int GROUP_W     = 8,
  parameter int MAX_GROUPS  = 3,
  parameter int UNIT_CYCLES = 1250000,
  parameter int HALF_CYC    = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic [1:0]        hw_stat,
  output logic              chain_sdo,
  output logic              chain_sclk,
  output logic              chain_store
);
  localparam int CHAIN_W = GROUP_W * MAX_GROUPS;

  logic [31:0]        ctrl_a_q, ctrl_b_q;
  logic [CHAIN_W-1:0] data_q;
  logic               sw_req, tick, busy, auto_en;
  logic               ctrl_unused;

  assign host_ready = 1'b1;
  assign auto_en = (ctrl_b_q[BIT_SRC_HI:BIT_SRC_LO] == 2'b10);
  assign ctrl_unused = ^{ctrl_a_q, ctrl_b_q};

  lsc_regs #(.ADDR_W(ADDR_W), .CHAIN_W(CHAIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ctrl_a(ctrl_a_q), .ctrl_b(ctrl_b_q),
    .data_word(data_q), .sw_req(sw_req)
  );

  lsc_rate #(.UNIT_CYCLES(UNIT_CYCLES)) u_rate (
    .clk(clk), .rst_n(rst_n),
    .auto_en(auto_en),
    .rate_code(ctrl_b_q[BIT_RATE_HI:BIT_RATE_LO]),
    .tick(tick)
  );

  lsc_shift #(.GROUP_W(GROUP_W), .MAX_GROUPS(MAX_GROUPS), .HALF_CYC(HALF_CYC)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .tick(tick), .sw_req(sw_req),
    .grp_en(ctrl_b_q[MAX_GROUPS-1:0]),
    .fall_live(ctrl_a_q[BIT_FALL]),
    .ovr_en(ctrl_a_q[BIT_OVR_HI] && ctrl_a_q[BIT_OVR_LO]),
    .hw_stat(hw_stat), .word(data_q),
    .sdo(chain_sdo), .sclk(chain_sclk), .store(chain_store), .busy(busy)
  );
endmodule

// File: rtl/led_chain_ctrl_chk.sv
module led_chain_ctrl_chk #(
  parameter int NG = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_valid,
  input logic          host_write,
  input logic          rd_valid,
  input logic          chain_sdo,
  input logic          chain_sclk,
  input logic          chain_store,
  input logic          busy,
  input logic [NG-1:0] grp_en
);
  // R2
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_write) |=> rd_valid);

  // R2
  rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(host_valid && !host_write));

  // R6
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chain_store) |=> chain_store);

  // R6
  store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_store && $past(chain_store)) |-> (!chain_sdo && $stable(chain_sclk)));

  // R4
  no_group_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && grp_en == '0) |=> !busy);

  // R6
  store_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_store |-> busy);
endmodule

bind led_chain_ctrl led_chain_ctrl_chk #(.NG(MAX_GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_valid(host_valid), .host_write(host_write),
  .rd_valid(rd_valid),
  .chain_sdo(chain_sdo), .chain_sclk(chain_sclk), .chain_store(chain_store),
  .busy(busy), .grp_en(ctrl_b_q[MAX_GROUPS-1:0])
);

// File: tb/led_chain_ctrl_tb.sv
`timescale 1ns/1ps
module led_chain_ctrl_tb;
  localparam int UNIT = 16;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready, rd_valid;
  logic [31:0] rd_data;
  logic [1:0]  hw_stat = 2'b00;
  logic        chain_sdo, chain_sclk, chain_store;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, edge_cnt = 0, strobe_cnt = 0;
  int prev_rise = 0, last_rise = 0, hi_run = 0, last_hi = 0;
  bit tb_fall = 1'b0;
  logic [23:0] casc = '0, latched = '0;

  always #2.5 clk = ~clk;

  led_chain_ctrl #(.UNIT_CYCLES(UNIT), .HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .hw_stat(hw_stat),
    .chain_sdo(chain_sdo), .chain_sclk(chain_sclk), .chain_store(chain_store)
  );

  // external chain model
  always @(posedge chain_sclk) if (!tb_fall) begin casc = {casc[22:0], chain_sdo}; edge_cnt++; end
  always @(negedge chain_sclk) if (tb_fall) begin casc = {casc[22:0], chain_sdo}; edge_cnt++; end
  always @(posedge chain_store) begin
    latched = casc; strobe_cnt++; prev_rise = last_rise; last_rise = cyc;
  end
  always @(posedge clk) begin
    cyc++;
    if (chain_store) hi_run++;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_addr = a;
    @(negedge clk);
    host_valid = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_strobes(input int target, input int limit);
    for (int k = 0; k < limit && strobe_cnt < target; k++) @(negedge clk);
  endtask

  function automatic int chain_len(input logic [2:0] g);
    return g[2] ? 24 : (g[1] ? 16 : (g[0] ? 8 : 0));
  endfunction

  task automatic run_shift(input logic [23:0] data, input logic [2:0] g, input bit fall,
                           input logic [1:0] ovr, input logic [1:0] stat);
    int len, s0;
    logic [23:0] exp_w, mask;
    len = chain_len(g);
    mask = (len == 24) ? 24'hFFFFFF : 24'((1 << len) - 1);
    exp_w = data;
    if (ovr == 2'b11) exp_w[1:0] = stat;
    hw_stat = stat;
    tb_fall = fall;
    wr(5'h08, 32'(data));
    wr(5'h04, 32'(g));
    wr(5'h00, (32'(fall) << 26) | (32'(ovr) << 24));
    idle(3);
    edge_cnt = 0; s0 = strobe_cnt;
    wr(5'h00, 32'h8000_0000 | (32'(fall) << 26) | (32'(ovr) << 24));
    wait_strobes(s0 + 1, 300);
    idle(8);
    // R3 R7: captured word in the active stages
    chk((latched & mask) == (exp_w & mask), "R3/R7 chain word", 32'(latched & mask), 32'(exp_w & mask));
    // R4 R5: one active edge per bit of the chosen length
    chk(edge_cnt == len, "R4/R5 edge count", 32'(edge_cnt), 32'(len));
    // R5: clock rests at the selected level
    chk(chain_sclk == fall, "R5 idle level", 32'(chain_sclk), 32'(fall));
  endtask

  task automatic run_periodic(input logic [1:0] src, input logic [3:0] rate, input logic [2:0] g,
                              input int exp_iv);
    int s0, s1;
    tb_fall = 1'b0;
    wr(5'h00, 32'h0);
    s0 = strobe_cnt;
    wr(5'h04, (32'(src) << 30) | (32'(rate) << 23) | 32'(g));
    if (exp_iv > 0) begin
      wait_strobes(s0 + 3, 2000);
      // R9 R10: interval between consecutive refreshes
      chk(last_rise - prev_rise == exp_iv, "R9/R10 refresh interval",
          32'(last_rise - prev_rise), 32'(exp_iv));
    end else begin
      idle(700);
      // R9: a source other than periodic gives no refresh
      chk(strobe_cnt == s0, "R9 no periodic refresh", 32'(strobe_cnt - s0), 32'h0);
    end
    wr(5'h04, 32'(g));
    idle(150);
    s1 = strobe_cnt;
    idle(700);
    chk(strobe_cnt == s1, "R9 refresh stops", 32'(strobe_cnt - s1), 32'h0);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    int s0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset outputs
    chk({chain_sdo, chain_sclk, chain_store} == 3'b000, "R1 outputs", 32'({chain_sdo, chain_sclk, chain_store}), 32'h0);
    for (int a = 0; a < 5; a++) begin
      rd(5'(a * 4), d, v);
      chk(d == 32'h0 && v, "R1 register reset", d, 32'h0);
    end
    // R2: map, widths, ready, unmapped
    chk(host_ready == 1'b1, "R2 ready", 32'(host_ready), 32'h1);
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, d, v);
    chk(d == 32'h00FF_FFFF, "R2 data width", d, 32'h00FF_FFFF);
    wr(5'h0C, 32'hDEAD_BEEF); rd(5'h0C, d, v);
    chk(d == 32'hDEAD_BEEF, "R2 spare", d, 32'hDEAD_BEEF);
    wr(5'h10, 32'h1234_5678); rd(5'h10, d, v);
    chk(d == 32'h1234_5678, "R2 access", d, 32'h1234_5678);
    wr(5'h04, 32'h8780_0005); rd(5'h04, d, v);
    chk(d == 32'h8780_0005, "R2 ctrl b", d, 32'h8780_0005);
    wr(5'h04, 32'h0);
    s0 = strobe_cnt;
    wr(5'h00, 32'h8300_0000); rd(5'h00, d, v);
    chk(d == 32'h0300_0000, "R2 request bit reads 0", d, 32'h0300_0000);
    rd(5'h14, d, v);
    chk(d == 32'h0 && v, "R2 unmapped", d, 32'h0);
    // R4: no group, request discarded, not held
    idle(100);
    chk(strobe_cnt == s0, "R4 no group no shift", 32'(strobe_cnt - s0), 32'h0);
    wr(5'h04, 32'h1);
    idle(100);
    chk(strobe_cnt == s0, "R4 request not kept", 32'(strobe_cnt - s0), 32'h0);

    // R3 R4 R5 R7 sweep
    for (int i = 0; i < 56; i++) begin
      logic [23:0] dat;
      dat = 24'h5A3C96 ^ 24'(i * 32'h01F35B) ^ 24'(i << 17);
      run_shift(dat, 3'(1 + i % 7), bit'((i / 7) % 2), 2'(i / 14), 2'(i) ^ 2'b10);
    end
    // R6: store width
    chk(last_hi == 2 * HALF, "R6 store width", 32'(last_hi), 32'(2 * HALF));

    // R8: held request uses data current when it is served
    wr(5'h04, 32'h7);
    wr(5'h00, 32'h0); tb_fall = 1'b0;
    wr(5'h08, 32'h00C0FFEE);
    s0 = strobe_cnt;
    wr(5'h00, 32'h8000_0000);
    idle(5);
    wr(5'h08, 32'h00ABCDEF);
    wr(5'h00, 32'h8000_0000);
    wr(5'h00, 32'h8000_0000);
    wait_strobes(s0 + 2, 400);
    idle(8);
    chk(latched == 24'hABCDEF, "R8 held request data", 32'(latched), 32'h00ABCDEF);
    idle(400);
    chk(strobe_cnt == s0 + 2, "R8 served once", 32'(strobe_cnt - s0), 32'h2);

    // R9 rates, R10 dropped ticks
    run_periodic(2'b10, 4'd0, 3'b001, 20 * UNIT);
    run_periodic(2'b10, 4'd1, 3'b001, 10 * UNIT);
    run_periodic(2'b10, 4'd2, 3'b001, 5 * UNIT);
    run_periodic(2'b10, 4'd3, 3'b001, 4 * UNIT);
    run_periodic(2'b10, 4'd5, 3'b001, 20 * UNIT);
    run_periodic(2'b10, 4'd3, 3'b111, 8 * UNIT);
    run_periodic(2'b10, 4'd2, 3'b100, 10 * UNIT);
    run_periodic(2'b11, 4'd3, 3'b001, 0);
    run_periodic(2'b01, 4'd3, 3'b001, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule